// File: doc/BRIEF.md
# Clock Control Register with Field Interlocks

This block holds the 8-bit control word of a small microcontroller clock unit. Software writes it through a simple strobe-and-data port and reads it back at any time. The word turns the PLL on and off, sets the PLL multiplication factor, chooses whether the system clock comes from the external input clock or from the PLL, and sets the divider for the peripheral clocks.

Hardware interlocks stop software from putting the clock tree into an unsafe state:
- The multiplication factor can be changed only once after each reset, and only while the system clock runs from the external input.
- The PLL source cannot be selected while the PLL is off.
- Turning the PLL off drops the source back to the external input.
- Stop mode and flash-programming mode force the PLL off at the outputs without changing the stored word.

The analog PLL and the glitch-free clock switch sit outside this block. They receive its run, factor and select outputs.

Top module: `clk_ctl_reg`

## Requirements
- R1: A synchronous reset loads the word 0x06: PLL enabled, factor code 01, external-clock source, divider code 00. With stop and flash inactive, `pll_run` is then 1 and `clk_mux_sel` is 0.
- R2: Bits 0 and 4 always read as 0, and writes to them are ignored.
- R3: Bits 7:6 (divider code) take the written value on every write and appear on `periph_div`.
- R4: Bit 1 (PLL enable) takes the written value on every write.
- R5: A write sets bit 5 (source = PLL) only if the stored enable is already 1 and the same write keeps bit 1 at 1. Otherwise a 1 written to bit 5 leaves it at 0.
- R6: A write that clears bit 1 also clears bit 5 in the same cycle.
- R7: Bits 3:2 hold the factor code (01 = ×2, 10 = ×3, 11 = ×4) and drive `pll_mult`. Code 00 is never stored.
- R8: After reset, the first accepted write that changes bits 3:2 to a different valid code is the only change allowed. Later factor writes are ignored until the next reset.
- R9: A factor write while bit 5 is 1, or a write of code 00, is ignored and does not use up the single permitted change.
- R10: While `stop_req` or `flash_mode` is 1, `pll_run` is 0 in the same cycle. The stored word and its readback stay unchanged.
- R11: `clk_mux_sel` is 1 only when bit 5 is 1 and `pll_run` is 1. Otherwise it selects the external clock.
- R12: `rd_data` shows the stored word, including any hardware-forced clear, from the clock edge that takes a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| stop_req | input | 1 | Stop mode active |
| flash_mode | input | 1 | Flash-programming mode active |
| rd_data | output | 8 | Readback of the stored word |
| pll_run | output | 1 | PLL run request after overrides |
| pll_mult | output | 2 | PLL multiplication factor code |
| sys_src_pll | output | 1 | Stored source-select bit |
| clk_mux_sel | output | 1 | Effective select to the clock multiplexer (1 = PLL) |
| periph_div | output | 2 | Peripheral clock divider code |

## Verification
Assertions check on every cycle that:
- the source bit is never set while the enable is clear,
- the factor code is never 00,
- the factor stays frozen once its change is used up, and stays frozen while the PLL is the source,
- the multiplexer never selects the PLL while the PLL is not running,
- the source bit only rises on a write made while the PLL was already enabled.

Only the bench's scenarios can show the rest:
- which write the single factor change goes to,
- that ignored factor writes do not use it up,
- that the lock is released by reset,
- that the readback is left untouched by the stop and flash overrides.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;
    localparam int WORD_W  = 8;
    localparam int BIT_EN  = 1;
    localparam int MULT_LO = 2;
    localparam int BIT_SRC = 5;
    localparam int DIV_LO  = 6;
    localparam int FIELD_W = 2;

    typedef enum logic [FIELD_W-1:0] {
        MULT_NONE = 2'b00,
        MULT_X2   = 2'b01,
        MULT_X3   = 2'b10,
        MULT_X4   = 2'b11
    } mult_e;

    typedef struct packed {
        logic [FIELD_W-1:0] div;
        logic               src;
        mult_e              mult;
        logic               en;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{div: 2'b00, src: 1'b0, mult: MULT_X2, en: 1'b1};

    function automatic logic [WORD_W-1:0] ctl_to_word(input ctl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_EN]                      = c.en;
        w[MULT_LO +: FIELD_W]          = c.mult;
        w[BIT_SRC]                     = c.src;
        w[DIV_LO +: FIELD_W]           = c.div;
        return w;
    endfunction

    function automatic ctl_t word_fields(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.en   = w[BIT_EN];
        c.mult = mult_e'(w[MULT_LO +: FIELD_W]);
        c.src  = w[BIT_SRC];
        c.div  = w[DIV_LO +: FIELD_W];
        return c;
    endfunction
endpackage

// File: rtl/ccr_en_src.sv
module ccr_en_src
    import clk_ctl_pkg::*;
#(
    parameter logic EN_RST = CTL_RESET.en
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_en_bit,
    input  logic wr_src_bit,
    output logic en_q,
    output logic src_q
);
    logic src_d;

    // Source may only become or stay PLL when enable was already on and stays on.
    always_comb begin
        src_d = src_q;
        if (wr_en) begin
            src_d = wr_src_bit & en_q & wr_en_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= EN_RST;
            src_q <= 1'b0;
        end else if (wr_en) begin
            en_q  <= wr_en_bit;
            src_q <= src_d;
        end
    end

    AST_SRC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !src_q);                                            // R6
    AST_SRC_RISE_ON_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(src_q) |-> ($past(en_q) && $past(wr_en)));             // R5
endmodule

// File: rtl/ccr_ratio.sv
module ccr_ratio
    import clk_ctl_pkg::*;
#(
    parameter mult_e MULT_RST = CTL_RESET.mult
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_mult,
    input  logic               src_q,
    output mult_e              mult_q
);
    logic used_q;
    logic take;

    // A change is taken once: valid code, different value, clock from external input.
    assign take = wr_en && !used_q && !src_q
               && (wr_mult != MULT_NONE) && (wr_mult != mult_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mult_q <= MULT_RST;
            used_q <= 1'b0;
        end else if (take) begin
            mult_q <= mult_e'(wr_mult);
            used_q <= 1'b1;
        end
    end

    AST_MULT_VALID: assert property (@(posedge clk) disable iff (rst)
        mult_q != MULT_NONE);                                         // R7
    AST_MULT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        used_q |=> $stable(mult_q));                                  // R8
    AST_MULT_HOLD_ON_PLL: assert property (@(posedge clk) disable iff (rst)
        src_q |=> $stable(mult_q));                                   // R9
endmodule

// File: rtl/ccr_gate.sv
module ccr_gate (
    input  logic en_q,
    input  logic src_q,
    input  logic stop_req,
    input  logic flash_mode,
    output logic pll_run,
    output logic mux_sel
);
    logic forced_off;

    always_comb begin
        forced_off = stop_req | flash_mode;
        pll_run    = en_q & ~forced_off;
        mux_sel    = src_q & pll_run;
    end
endmodule

// File: rtl/clk_ctl_reg.sv
module clk_ctl_reg
    import clk_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              stop_req,
    input  logic              flash_mode,
    output logic [WORD_W-1:0] rd_data,
    output logic              pll_run,
    output logic [1:0]        pll_mult,
    output logic              sys_src_pll,
    output logic              clk_mux_sel,
    output logic [1:0]        periph_div
);
    ctl_t              wr_f;
    ctl_t              cur;
    logic              en_q;
    logic              src_q;
    mult_e             mult_q;
    logic [FIELD_W-1:0] div_q;
    logic              unused_rsvd;

    assign wr_f        = word_fields(wr_data);
    assign unused_rsvd = wr_data[0] ^ wr_data[4];

    ccr_en_src u_en_src (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_en_bit  (wr_f.en),
        .wr_src_bit (wr_f.src),
        .en_q       (en_q),
        .src_q      (src_q)
    );

    ccr_ratio u_ratio (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_mult (wr_f.mult),
        .src_q   (src_q),
        .mult_q  (mult_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= CTL_RESET.div;
        end else if (wr_en) begin
            div_q <= wr_f.div;
        end
    end

    ccr_gate u_gate (
        .en_q       (en_q),
        .src_q      (src_q),
        .stop_req   (stop_req),
        .flash_mode (flash_mode),
        .pll_run    (pll_run),
        .mux_sel    (clk_mux_sel)
    );

    always_comb begin
        cur.div  = div_q;
        cur.src  = src_q;
        cur.mult = mult_q;
        cur.en   = en_q;
    end

    assign rd_data     = ctl_to_word(cur);
    assign pll_mult    = mult_q;
    assign sys_src_pll = src_q;
    assign periph_div  = div_q;

    AST_MUX_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        clk_mux_sel |-> (pll_run && sys_src_pll));                   // R11
    AST_OVERRIDE_STOPS_PLL: assert property (@(posedge clk) disable iff (rst)
        (stop_req || flash_mode) |-> !pll_run);                      // R10
endmodule

// File: tb/clk_ctl_reg_test.sv
module clk_ctl_reg_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stop_req = 1'b0;
    logic       flash_mode = 1'b0;
    logic [7:0] rd_data;
    logic       pll_run;
    logic [1:0] pll_mult;
    logic       sys_src_pll;
    logic       clk_mux_sel;
    logic [1:0] periph_div;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clk_ctl_reg uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .stop_req(stop_req), .flash_mode(flash_mode), .rd_data(rd_data),
        .pll_run(pll_run), .pll_mult(pll_mult), .sys_src_pll(sys_src_pll),
        .clk_mux_sel(clk_mux_sel), .periph_div(periph_div)
    );

    // {write word, expected readback}
    localparam logic [15:0] VEC [9] = '{
        16'hC2_C6,  // R3 divider 11, R9 code 00 ignored
        16'h22_26,  // R5 source set with enable held
        16'h2E_26,  // R9 factor write while on PLL ignored
        16'h20_04,  // R6 enable clear forces source clear, R4
        16'h22_06,  // R5 set both while enable was 0: source stays 0
        16'h0A_0A,  // R8 first change to x3 taken
        16'h0E_0A,  // R8 second change ignored
        16'h9B_8A,  // R2 reserved bits ignored
        16'h62_6A   // R3 R5 R12
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 rd", rd_data, 8'h06);
        chk("R1 run", {7'b0, pll_run}, 8'h01);
        chk("R1 mux", {7'b0, clk_mux_sel}, 8'h00);
        chk("R7 mult", {6'b0, pll_mult}, 8'h01);

        for (int i = 0; i < 9; i++) begin
            do_write(VEC[i][15:8]);
            chk("R12 vector", rd_data, VEC[i][7:0]);
            if (i == 3) chk("R4 run off", {7'b0, pll_run}, 8'h00);
        end
        chk("R3 div", {6'b0, periph_div}, 8'h01);
        chk("R7 mult x3", {6'b0, pll_mult}, 8'h02);
        chk("R11 mux on", {7'b0, clk_mux_sel}, 8'h01);
        chk("R5 src", {7'b0, sys_src_pll}, 8'h01);

        @(negedge clk); stop_req = 1'b1;
        #1;
        chk("R10 stop run", {7'b0, pll_run}, 8'h00);
        chk("R11 stop mux", {7'b0, clk_mux_sel}, 8'h00);
        @(negedge clk);
        chk("R10 stop rd", rd_data, 8'h6A);
        stop_req = 1'b0; flash_mode = 1'b1;
        #1;
        chk("R10 flash run", {7'b0, pll_run}, 8'h00);
        chk("R11 flash mux", {7'b0, clk_mux_sel}, 8'h00);
        @(negedge clk);
        flash_mode = 1'b0;
        #1;
        chk("R10 release rd", rd_data, 8'h6A);
        chk("R11 release mux", {7'b0, clk_mux_sel}, 8'h01);

        do_reset();
        chk("R1 after reset", rd_data, 8'h06);
        do_write(8'h0E);
        chk("R8 change after reset", rd_data, 8'h0E);
        chk("R7 mult x4", {6'b0, pll_mult}, 8'h03);
        do_write(8'h0A);
        chk("R8 relocked", rd_data, 8'h0E);
        done = 1'b1;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
    end

    initial begin
        wait (done || checks < 0);
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5001) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule